// File: doc/BRIEF.md
# Straight-Through Clipped Weight Updater

This block performs the training-side update of a single latent weight in a binarized network layer. Each accepted beat carries three fixed-point values: the pre-binarization activation, the gradient arriving from downstream, and the current latent weight. The gradient is first gated by a straight-through rule. It passes when the activation magnitude is at most one and is forced to zero otherwise. It is then divided by a power of two chosen through a shift setting. The result is subtracted from the latent weight.

The difference is formed one bit wider than the data path and saturated to the interval from minus one to plus one. It is returned as the new latent weight together with its sign bit, which is the binary weight for the forward pass. The caller stores the returned weight and presents it again on a later update. Beats flow through a two-stage pipeline, so the block accepts one update every clock.

Top module: `ste_weight_update`

## Requirements
- R1: When the activation lies within [-1, +1] inclusive (raw values -16384 to 16384 with 14 fraction bits), the gradient is used unchanged in the update.
- R2: When the activation lies outside [-1, +1], the gradient is treated as zero, and the returned weight equals the incoming weight after clipping.
- R3: The learning-rate scaling is an arithmetic right shift of the gated gradient by `lr_shift` (0 to 15) bits, rounding toward minus infinity.
- R4: Before clipping, the new weight is the incoming weight minus the scaled gradient.
- R5: Any result above +1 is returned as exactly +1 (raw 16384).
- R6: Any result below -1 is returned as exactly -1 (raw -16384).
- R7: The subtraction cannot wrap. Full-scale operands of opposite sign still saturate to the bound on the correct side.
- R8: `out_sign` is 1 when the returned weight is zero or positive and 0 when it is negative, so zero maps to +1.
- R9: Each beat accepted with `in_valid` high produces exactly one `out_valid` beat two clock edges later, in order, at a rate of one per cycle.
- R10: While `rst` is high, and on the first cycles after it is released, `out_valid` is 0, `out_wgt` is 0 and `out_sign` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Update beat present |
| in_act | input | 16 | Signed activation that fed the sign function, 14 fraction bits |
| in_grad | input | 16 | Signed upstream gradient, 14 fraction bits |
| in_wgt | input | 16 | Signed latent weight before update, 14 fraction bits |
| lr_shift | input | 4 | Learning rate as a right-shift count |
| out_valid | output | 1 | Updated weight present |
| out_wgt | output | 16 | Clipped updated latent weight |
| out_sign | output | 1 | Binary weight: 1 for +1, 0 for -1 |

## Verification
The bench builds the block with its defaults: 16-bit data with 14 fraction bits and a 4-bit shift count. With these values the gate thresholds and clip bounds are exact raw integers (plus and minus 16384), so the bench can hit the one-LSB edges on both sides of each. The bench also covers every shift count from 0 to 15 and full-scale operands that would wrap in a 16-bit subtraction. Directed beats, back-to-back streams with gaps, and a few hundred random beats are checked against an integer model, including the exact output cycle of each beat.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_FRAC_W  = 14;
  localparam int DEF_SHIFT_W = 4;

  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_HIGH = 2'd1,
    CLIP_LOW  = 2'd2
  } clip_kind_e;
endpackage

// File: rtl/wupd_gate_scale.sv
module wupd_gate_scale #(
  parameter int DATA_W  = wupd_pkg::DEF_DATA_W,
  parameter int FRAC_W  = wupd_pkg::DEF_FRAC_W,
  parameter int SHIFT_W = wupd_pkg::DEF_SHIFT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_act,
  input  logic signed [DATA_W-1:0] in_grad,
  input  logic signed [DATA_W-1:0] in_wgt,
  input  logic [SHIFT_W-1:0]       lr_shift,
  output logic                     s1_valid,
  output logic signed [DATA_W-1:0] s1_step,
  output logic signed [DATA_W-1:0] s1_wgt
);
  localparam int                     ONE_I   = 1 << FRAC_W;
  localparam logic signed [DATA_W-1:0] UNIT_P = DATA_W'(ONE_I);
  localparam logic signed [DATA_W-1:0] UNIT_N = -UNIT_P;

  logic                     act_in_window;
  logic signed [DATA_W-1:0] gated_grad;
  logic signed [DATA_W-1:0] scaled_grad;

  // straight-through window: |act| <= 1
  always_comb begin
    act_in_window = (in_act <= UNIT_P) && (in_act >= UNIT_N);
    gated_grad    = act_in_window ? in_grad : '0;
    scaled_grad   = gated_grad >>> lr_shift;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_step  <= '0;
      s1_wgt   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_step <= scaled_grad;
        s1_wgt  <= in_wgt;
      end
    end
  end
endmodule

// File: rtl/wupd_clip_sign.sv
module wupd_clip_sign #(
  parameter int DATA_W = wupd_pkg::DEF_DATA_W,
  parameter int FRAC_W = wupd_pkg::DEF_FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic signed [DATA_W-1:0] s1_step,
  input  logic signed [DATA_W-1:0] s1_wgt,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_wgt,
  output logic                     out_sign
);
  import wupd_pkg::*;

  localparam int                       EXT_W  = DATA_W + 1;
  localparam int                       ONE_I  = 1 << FRAC_W;
  localparam logic signed [EXT_W-1:0]  HI_X   = EXT_W'(ONE_I);
  localparam logic signed [EXT_W-1:0]  LO_X   = -HI_X;
  localparam logic signed [DATA_W-1:0] HI_D   = DATA_W'(ONE_I);
  localparam logic signed [DATA_W-1:0] LO_D   = -HI_D;

  logic signed [EXT_W-1:0]  wide_diff;
  logic signed [DATA_W-1:0] clipped;
  clip_kind_e               kind;

  always_comb begin
    wide_diff = {s1_wgt[DATA_W-1], s1_wgt} - {s1_step[DATA_W-1], s1_step};
    if (wide_diff > HI_X)      kind = CLIP_HIGH;
    else if (wide_diff < LO_X) kind = CLIP_LOW;
    else                       kind = CLIP_NONE;
    case (kind)
      CLIP_HIGH: clipped = HI_D;
      CLIP_LOW:  clipped = LO_D;
      default:   clipped = wide_diff[DATA_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wgt   <= '0;
      out_sign  <= 1'b1;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_wgt  <= clipped;
        out_sign <= ~clipped[DATA_W-1];
      end
    end
  end
endmodule

// File: rtl/ste_weight_update.sv
module ste_weight_update #(
  parameter int DATA_W  = wupd_pkg::DEF_DATA_W,
  parameter int FRAC_W  = wupd_pkg::DEF_FRAC_W,
  parameter int SHIFT_W = wupd_pkg::DEF_SHIFT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_act,
  input  logic signed [DATA_W-1:0] in_grad,
  input  logic signed [DATA_W-1:0] in_wgt,
  input  logic [SHIFT_W-1:0]       lr_shift,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_wgt,
  output logic                     out_sign
);
  logic                     s1_valid;
  logic signed [DATA_W-1:0] s1_step;
  logic signed [DATA_W-1:0] s1_wgt;

  wupd_gate_scale #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .SHIFT_W(SHIFT_W)
  ) u_gate_scale (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_act  (in_act),
    .in_grad (in_grad),
    .in_wgt  (in_wgt),
    .lr_shift(lr_shift),
    .s1_valid(s1_valid),
    .s1_step (s1_step),
    .s1_wgt  (s1_wgt)
  );

  wupd_clip_sign #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W)
  ) u_clip_sign (
    .clk      (clk),
    .rst      (rst),
    .s1_valid (s1_valid),
    .s1_step  (s1_step),
    .s1_wgt   (s1_wgt),
    .out_valid(out_valid),
    .out_wgt  (out_wgt),
    .out_sign (out_sign)
  );
endmodule

// File: rtl/wupd_checker.sv
module wupd_checker #(
  parameter int DATA_W  = wupd_pkg::DEF_DATA_W,
  parameter int FRAC_W  = wupd_pkg::DEF_FRAC_W,
  parameter int SHIFT_W = wupd_pkg::DEF_SHIFT_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_act,
  input logic signed [DATA_W-1:0] in_wgt,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_wgt,
  input logic                     out_sign
);
  localparam int                       ONE_I  = 1 << FRAC_W;
  localparam logic signed [DATA_W-1:0] HI_D   = DATA_W'(ONE_I);
  localparam logic signed [DATA_W-1:0] LO_D   = -HI_D;

  logic [1:0] age;
  logic       act_out;
  logic signed [DATA_W-1:0] wgt_clipped;

  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    act_out = (in_act > HI_D) || (in_act < LO_D);
    if (in_wgt > HI_D)      wgt_clipped = HI_D;
    else if (in_wgt < LO_D) wgt_clipped = LO_D;
    else                    wgt_clipped = in_wgt;
  end

  // R9: one output beat two edges after each input beat
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R5: never above +1
  a_r5_upper_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_wgt <= HI_D));

  // R6: never below -1
  a_r6_lower_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_wgt >= LO_D));

  // R8: sign bit agrees with the returned weight, zero maps to +1
  a_r8_sign_match: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sign == (out_wgt >= 0)));

  // R2: outside the window only the clipped incoming weight comes back
  a_r2_blocked_grad: assert property (@(posedge clk) disable iff (rst)
    ((age >= 2'd2) && $past(in_valid, 2) && $past(act_out, 2))
      |-> (out_wgt == $past(wgt_clipped, 2)));

  // R10: nothing emerges on the first cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_sign));
endmodule

bind ste_weight_update wupd_checker #(
  .DATA_W (DATA_W),
  .FRAC_W (FRAC_W),
  .SHIFT_W(SHIFT_W)
) u_wupd_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_act   (in_act),
  .in_wgt   (in_wgt),
  .out_valid(out_valid),
  .out_wgt  (out_wgt),
  .out_sign (out_sign)
);

// File: tb/ste_weight_update_bench.sv
module ste_weight_update_bench;
  localparam int DW  = 16;
  localparam int FW  = 14;
  localparam int SW  = 4;
  localparam int ONE = 1 << FW;

  typedef struct {
    int    wgt;
    bit    sign;
    int    issue;
    string req;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_act = '0;
  logic signed [DW-1:0] in_grad = '0;
  logic signed [DW-1:0] in_wgt = '0;
  logic [SW-1:0]        lr_shift = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_wgt;
  logic                 out_sign;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   n_push = 0;
  int   n_pop = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ste_weight_update u_ste_weight_update (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_act(in_act),
    .in_grad(in_grad), .in_wgt(in_wgt), .lr_shift(lr_shift),
    .out_valid(out_valid), .out_wgt(out_wgt), .out_sign(out_sign)
  );

  function automatic int model(input int act, input int grad, input int wgt, input int sh);
    int g, st, d;
    g  = (act >= -ONE && act <= ONE) ? grad : 0;
    st = g >>> sh;
    d  = wgt - st;
    if (d > ONE)  d = ONE;
    if (d < -ONE) d = -ONE;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic drive(input int act, input int grad, input int wgt, input int sh, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_act   = DW'(act);
    in_grad  = DW'(grad);
    in_wgt   = DW'(wgt);
    lr_shift = SW'(sh);
    e.wgt   = model(act, grad, wgt, sh);
    e.sign  = (e.wgt >= 0);
    e.issue = cyc;
    e.req   = req;
    q.push_back(e);
    n_push++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_act   = 16'sh7abc;
      in_grad  = 16'sh1234;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected beat", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_pop++;
        check(cyc == e.issue + 2, {"R9 latency for ", e.req}, cyc - e.issue, 2);
        check(int'(out_wgt) == e.wgt, e.req, int'(out_wgt), e.wgt);
        check(out_sign == e.sign, {"R8 sign for ", e.req}, int'(out_sign), int'(e.sign));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: beats during reset must not emerge
    in_valid = 1'b1;
    in_wgt   = 16'sd1000;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
    check(out_wgt == '0, "R10 weight in reset", int'(out_wgt), 0);
    check(out_sign == 1'b1, "R10 sign in reset", int'(out_sign), 1);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid after release", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid two after release", int'(out_valid), 0);
    mon_on = 1'b1;

    // R1 window edges, inclusive
    drive(ONE, 1000, 0, 0, "R1 act=+1");
    drive(-ONE, -1000, 0, 2, "R1 act=-1");
    idle(1);
    // R2 just outside the window
    drive(ONE + 1, 5000, 3000, 0, "R2 act above");
    drive(-ONE - 1, -30000, -100, 0, "R2 act below");
    drive(30000, 7000, 20000, 0, "R2 clipped passthrough");
    // R3 floor rounding, every shift count
    drive(0, -7, 0, 1, "R3 floor -7>>1");
    drive(0, 7, 0, 1, "R3 7>>1");
    drive(0, -32768, 10, 15, "R3 shift 15");
    for (int s = 0; s < 16; s++) drive(100, 12345, -50, s, "R3 shift sweep");
    // R4 plain subtraction
    drive(0, 300, 1200, 0, "R4 subtract");
    drive(-5, -4096, -8192, 1, "R4 subtract neg");
    // R5 / R6 saturation
    drive(0, -2000, 16000, 0, "R5 clip high");
    drive(0, -1, ONE, 0, "R5 one past top");
    drive(0, 2000, -16000, 0, "R6 clip low");
    drive(0, 1, -ONE, 0, "R6 one past bottom");
    // R7 full-scale, no wrap
    drive(0, -32768, 32767, 0, "R7 wide positive");
    drive(0, 32767, -32768, 0, "R7 wide negative");
    // R8 zero maps to +1
    drive(0, 500, 500, 0, "R8 zero result");
    drive(0, 1, 0, 0, "R8 minus one lsb");
    idle(3);
    // R9 streaming with gaps
    for (int i = 0; i < 300; i++) begin
      int a, g, w;
      a = int'($signed(16'($urandom_range(0, 65535))));
      if (i % 3 == 0) a = a % (ONE + 2);
      g = int'($signed(16'($urandom_range(0, 65535))));
      w = int'($signed(16'($urandom_range(0, 65535))));
      if (i % 2 == 0) w = w % (ONE + 1);
      drive(a, g, w, int'($urandom_range(0, 15)), "R9 random stream");
      if (i % 17 == 0) idle(2);
    end
    idle(5);
    check(q.size() == 0, "R9 leftover expected beats", q.size(), 0);
    check(n_pop == n_push, "R9 beat count", n_pop, n_push);
    finish_run();
  end
endmodule